// File: doc/BRIEF.md
# Serial Channel Enable Latch Bank

This block holds the power enables of a dual-channel serial transceiver. One shared 4-bit enable bus feeds three independent latches:

- the transmit-driver latch;
- the receive-channel latch;
- the self-test latch.

Each latch has its own load strobe. The latches are modelled as registers sampled on the system clock. While a strobe is seen high at a rising clock edge, its latch follows the bus. At the first edge where the strobe is seen low, the latch keeps the last value it took.

The transceiver has two channels, and each channel owns two adjacent bus bits. For the transmit latch, each bit enables one serial driver. A channel's internal transmit logic is flagged as powered down only when both of its drivers are off. Receive and self-test enables are reduced per channel from their own two bits.

Reset is asynchronous and active-low. It is applied at once and released through a two-stage synchronizer. Reset clears the transmit and receive latches and presets the self-test latch, whose bits are active-low. After reset, every channel is therefore disabled and self-test is off.

A system that needs no dynamic power control can tie the strobes and the bus high. The channels then come up enabled shortly after reset is released.

Top module: `chen_latch_bank`

## Requirements
- R1: While reset is held, tx_drv_en = 0, rx_ch_en = 0, tx_logic_pd = 2'b11 and selftest_on = 0. The self-test latch reads all ones.
- R2: After a rising edge at which tx_stb is high, tx_drv_en equals the value en_bus had at that edge. Bit i enables serial driver i.
- R3: After a rising edge at which tx_stb is low, tx_drv_en keeps its previous value whatever en_bus does.
- R4: tx_logic_pd[c] is high exactly when tx_drv_en[2c] and tx_drv_en[2c+1] are both low, for c = 0 and 1.
- R5: The receive latch loads from en_bus on edges with rx_stb high and holds on edges with it low. rx_ch_en[c] is the OR of latched bits 2c and 2c+1.
- R6: The self-test latch loads from en_bus on edges with st_stb high and holds otherwise. Its bits are active-low: selftest_on[c] is high when latched bit 2c or bit 2c+1 is low.
- R7: A strobe loads only its own latch. The outputs derived from the other two latches are unchanged by that load.
- R8: With all strobes and en_bus tied high, outputs keep their reset values through the second rising edge after rst_n rises. They are all enabled after the third edge: tx_drv_en = 4'hF, rx_ch_en = 2'b11, tx_logic_pd = 0, selftest_on = 0.
- R9: Driving rst_n low returns all outputs to the R1 state without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_bus | input | 4 | Shared enable bus, two bits per channel |
| tx_stb | input | 1 | Load strobe of the transmit-driver latch |
| rx_stb | input | 1 | Load strobe of the receive-channel latch |
| st_stb | input | 1 | Load strobe of the self-test latch |
| tx_drv_en | output | 4 | Per-driver serial transmit enables |
| tx_logic_pd | output | 2 | Per-channel transmit-logic power-down flag |
| rx_ch_en | output | 2 | Per-channel receive enables |
| selftest_on | output | 2 | Per-channel self-test active |

## Verification
The hardest case to reach is the strapped power-up of R8. There, all strobes and the bus are already high while reset is held. The outputs must then stay in the reset state for exactly as long as the release synchronizer takes, and become enabled on the next edge.

The bench holds that configuration through reset and releases rst_n between clock edges. It then samples after each of the following edges, so the exact edge of enabling is pinned down.

The other cases come from full sweeps of all 16 bus values through each latch. Each load is followed by a hold cycle in which the bus carries the complement. The bench also samples the outputs of the two untouched latches to show that the load did not reach them.

// File: rtl/chen_pkg.sv
package chen_pkg;
  localparam int CH_COUNT      = 2;
  localparam int DRV_PER_CHAN  = 2;
  localparam int EN_BUS_W      = CH_COUNT * DRV_PER_CHAN;
  localparam int RST_STAGES    = 2;
endpackage

// File: rtl/chen_rst_sync.sv
module chen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/chen_latch.sv
module chen_latch #(
  parameter int             W      = 4,
  parameter logic [W-1:0]   PRESET = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (stb) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= PRESET;
    else        q <= q_nxt;
  end

  // R2
  load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (q == $past(d)));

  // R3
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(q));
endmodule

// File: rtl/chen_chan_map.sv
module chen_chan_map #(
  parameter int NUM_CH = 2,
  parameter int DRV    = 2
) (
  input  logic [NUM_CH*DRV-1:0] tx_q,
  input  logic [NUM_CH*DRV-1:0] rx_q,
  input  logic [NUM_CH*DRV-1:0] st_q,
  output logic [NUM_CH-1:0]     tx_pd,
  output logic [NUM_CH-1:0]     rx_en,
  output logic [NUM_CH-1:0]     st_on
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign tx_pd[c] = ~(|tx_q[c*DRV +: DRV]);
    assign rx_en[c] =   |rx_q[c*DRV +: DRV];
    assign st_on[c] = ~(&st_q[c*DRV +: DRV]);
  end
endmodule

// File: rtl/chen_latch_bank.sv
module chen_latch_bank #(
  parameter int NUM_CH = chen_pkg::CH_COUNT,
  parameter int DRV    = chen_pkg::DRV_PER_CHAN
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH*DRV-1:0] en_bus,
  input  logic                  tx_stb,
  input  logic                  rx_stb,
  input  logic                  st_stb,
  output logic [NUM_CH*DRV-1:0] tx_drv_en,
  output logic [NUM_CH-1:0]     tx_logic_pd,
  output logic [NUM_CH-1:0]     rx_ch_en,
  output logic [NUM_CH-1:0]     selftest_on
);
  localparam int BW = NUM_CH * DRV;

  logic          rst_sync_n;
  logic [BW-1:0] tx_q;
  logic [BW-1:0] rx_q;
  logic [BW-1:0] st_q;

  chen_rst_sync #(.STAGES(chen_pkg::RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  chen_latch #(.W(BW), .PRESET({BW{1'b0}})) u_tx (
    .clk(clk), .rst_n(rst_sync_n), .stb(tx_stb), .d(en_bus), .q(tx_q)
  );

  chen_latch #(.W(BW), .PRESET({BW{1'b0}})) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .stb(rx_stb), .d(en_bus), .q(rx_q)
  );

  chen_latch #(.W(BW), .PRESET({BW{1'b1}})) u_st (
    .clk(clk), .rst_n(rst_sync_n), .stb(st_stb), .d(en_bus), .q(st_q)
  );

  chen_chan_map #(.NUM_CH(NUM_CH), .DRV(DRV)) u_map (
    .tx_q(tx_q), .rx_q(rx_q), .st_q(st_q),
    .tx_pd(tx_logic_pd), .rx_en(rx_ch_en), .st_on(selftest_on)
  );

  assign tx_drv_en = tx_q;

  // R1
  rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (tx_drv_en == '0 && rx_ch_en == '0 &&
                           selftest_on == '0 && tx_logic_pd == '1));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pd_chk
    // R4
    drv_on_not_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|tx_drv_en[c*DRV +: DRV]) |-> !tx_logic_pd[c]);
  end
endmodule

// File: tb/chen_latch_bank_tb_top.sv
module chen_latch_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] en_bus;
  logic       tx_stb, rx_stb, st_stb;
  logic [3:0] tx_drv_en;
  logic [1:0] tx_logic_pd, rx_ch_en, selftest_on;

  int checks = 0;
  int errors = 0;

  logic [3:0] e_tx, e_rx, e_st;

  always #(CLK_PERIOD/2) clk = ~clk;

  chen_latch_bank dut_i (
    .clk(clk), .rst_n(rst_n), .en_bus(en_bus),
    .tx_stb(tx_stb), .rx_stb(rx_stb), .st_stb(st_stb),
    .tx_drv_en(tx_drv_en), .tx_logic_pd(tx_logic_pd),
    .rx_ch_en(rx_ch_en), .selftest_on(selftest_on)
  );

  function automatic logic [1:0] pd_of(input logic [3:0] v);
    pd_of[0] = (v[1:0] == 2'b00);
    pd_of[1] = (v[3:2] == 2'b00);
  endfunction
  function automatic logic [1:0] any_of(input logic [3:0] v);
    any_of[0] = (v[1:0] != 2'b00);
    any_of[1] = (v[3:2] != 2'b00);
  endfunction
  function automatic logic [1:0] st_of(input logic [3:0] v);
    st_of[0] = (v[1:0] != 2'b11);
    st_of[1] = (v[3:2] != 2'b11);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, {4'h0, tx_drv_en},   {4'h0, e_tx});
    chk(req, {6'h0, tx_logic_pd}, {6'h0, pd_of(e_tx)});
    chk(req, {6'h0, rx_ch_en},    {6'h0, any_of(e_rx)});
    chk(req, {6'h0, selftest_on}, {6'h0, st_of(e_st)});
  endtask

  task automatic step(input logic [3:0] b, input logic t, input logic r, input logic s);
    @(negedge clk);
    en_bus = b; tx_stb = t; rx_stb = r; st_stb = s;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: strapped configuration held through reset
    rst_n = 1'b0; en_bus = 4'hF; tx_stb = 1'b1; rx_stb = 1'b1; st_stb = 1'b1;
    e_tx = 4'h0; e_rx = 4'h0; e_st = 4'hF;
    repeat (3) @(posedge clk);
    #1 chk_all("R1");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 chk_all("R8");
    @(posedge clk); #1 chk_all("R8");
    @(posedge clk); #1;
    e_tx = 4'hF; e_rx = 4'hF; e_st = 4'hF;
    chk_all("R8");

    // R9: asynchronous return to reset state
    @(negedge clk); #1 rst_n = 1'b0; #1;
    e_tx = 4'h0; e_rx = 4'h0; e_st = 4'hF;
    chk_all("R9");
    tx_stb = 1'b0; rx_stb = 1'b0; st_stb = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk_all("R1");

    // R2 R3 R4 R7: transmit latch sweep
    for (int v = 0; v < 16; v++) begin
      step(v[3:0], 1'b1, 1'b0, 1'b0);
      e_tx = v[3:0];
      chk_all("R2_R4_R7");
      step(~v[3:0], 1'b0, 1'b0, 1'b0);
      chk_all("R3");
    end

    // R5 R7: receive latch sweep
    for (int v = 0; v < 16; v++) begin
      step(v[3:0], 1'b0, 1'b1, 1'b0);
      e_rx = v[3:0];
      chk_all("R5_R7");
      step(~v[3:0], 1'b0, 1'b0, 1'b0);
      chk_all("R5");
    end

    // R6 R7: self-test latch sweep
    for (int v = 0; v < 16; v++) begin
      step(v[3:0], 1'b0, 1'b0, 1'b1);
      e_st = v[3:0];
      chk_all("R6_R7");
      step(~v[3:0], 1'b0, 1'b0, 1'b0);
      chk_all("R6");
    end

    // R3: strobe held high over several edges, then dropped
    step(4'h5, 1'b1, 1'b0, 1'b0);
    step(4'hA, 1'b1, 1'b0, 1'b0);
    e_tx = 4'hA;
    chk_all("R2");
    step(4'h3, 1'b0, 1'b0, 1'b0);
    step(4'hC, 1'b0, 1'b0, 1'b0);
    chk_all("R3");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule